// File: doc/BRIEF.md
# ADC Conversion Sequence Trigger Controller

This block decides when the conversion engine of an analog-to-digital converter begins a conversion sequence. A sequence can be launched in two ways. Software can pulse a start strobe, and the sequence then runs once or repeats without end. An external trigger pin can also launch sequences, either on an edge or for as long as a level holds, with a selectable polarity. The block raises a one-cycle start pulse for the engine and holds a busy indicator until the engine reports that the sequence is complete.

The trigger pin passes through a synchronizer before any decision is made. While external triggering is enabled, the software strobe and the scan bit are ignored. In edge mode, an active edge that arrives while a sequence is running is lost and sets a sticky error flag, which stays set until a dedicated clear pulse. All decisions are made at the point where the block is idle or the running sequence completes. Control bits that change while a sequence is running therefore take effect only from the next such point, and they never abort a sequence already under way.

Top module: `adc_seq_trigger`

## Requirements
- R1: With `ext_en`=0 and `scan`=0, a `sw_start` pulse while idle produces exactly one `seq_start` pulse. `busy` then returns to 0 after `seq_done` and stays there.
- R2: With `ext_en`=0 and `scan`=1, a software start is followed by repeated sequences: each `seq_done` launches the next one. After `scan` is cleared, the following `seq_done` ends the activity.
- R3: With `ext_en`=1 and `lvl_mode`=0, `pol`=1 launches one sequence per rising edge of `trig_pin` and `pol`=0 launches one per falling edge. Edges of the opposite direction launch nothing.
- R4: With `ext_en`=1 and `lvl_mode`=1, sequences repeat for as long as the synchronized pin equals `pol` (1 = active high, 0 = active low). They stop once the pin leaves that level.
- R5: With `ext_en`=1, neither `sw_start` nor `scan` launches a sequence.
- R6: In edge mode, an active edge detected while `busy`=1 and `seq_done`=0 sets `ovr_flag` and queues no extra sequence.
- R7: In level mode, the pin leaving and re-entering its active level during a sequence never sets `ovr_flag`.
- R8: In level mode, if the trigger is still active in the cycle where `seq_done` is high, `seq_start` pulses in the very next cycle.
- R9: `ovr_flag` stays set until an `ovr_clr` pulse. If an overrun event and `ovr_clr` occur in the same cycle, the flag ends up set.
- R10: The pin is synchronized by two flops, and edge detection adds one cycle. Counting the first rising clock edge that samples a new pin level as edge one, `seq_start` is high after edge three.
- R11: Changing `ext_en`, `lvl_mode`, `pol` or `scan` while `busy`=1 does not end the sequence: `busy` stays high until `seq_done`.
- R12: While `rst_n`=0, `seq_start`, `busy` and `ovr_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | 1 = external pin launches sequences, software start ignored |
| lvl_mode | input | 1 | 0 = edge sensitive, 1 = level sensitive |
| pol | input | 1 | Trigger polarity: 1 = rising/high, 0 = falling/low |
| scan | input | 1 | Continuous software-launched sequences when 1 |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| sw_start | input | 1 | Software start strobe |
| seq_done | input | 1 | Sequence-complete pulse from the conversion engine |
| ovr_clr | input | 1 | Clears the overrun flag |
| seq_start | output | 1 | One-cycle sequence launch pulse |
| busy | output | 1 | A sequence is in progress |
| ovr_flag | output | 1 | Sticky trigger-overrun flag |

## Verification
The launch logic is tried under each of its six mode combinations: software one-shot, software scan, rising edge, falling edge, active-high level and active-low level. Opposite-direction edges and the inactive level distinguish the polarity handling from plain change detection. A second edge during a long sequence is set against a level dip-and-return during a long sequence, which separates the overrun rule of edge mode from that of level mode. A clear pulse timed onto the overrun cycle shows which of set and clear takes priority. Mode bits flipped while a sequence is running show that a sequence in progress is never cut short.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef struct packed {
    logic ext_en;
    logic lvl_mode;
    logic pol;
    logic scan;
  } trig_ctrl_t;

  // Level seen as active under the chosen polarity.
  function automatic logic lvl_active(input logic pol, input logic s);
    return pol ? s : ~s;
  endfunction

  // Active transition between two consecutive synchronized samples.
  function automatic logic edge_seen(input logic pol, input logic cur, input logic prev);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sync_o,
  output logic sync_prev_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  // One more stage holds the previous synchronized sample for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];
  end

  assign sync_o      = chain[LAST];
  assign sync_prev_o = prev_q;

endmodule

// File: rtl/adc_trig_decide.sv
module adc_trig_decide
  import adc_trig_pkg::*;
(
  input  trig_ctrl_t ctrl_i,
  input  logic       sync_i,
  input  logic       sync_prev_i,
  input  logic       sw_start_i,
  input  logic       seq_done_i,
  input  logic       busy_i,
  output logic       edge_hit_o,
  output logic       lvl_act_o,
  output logic       launch_o,
  output logic       ovr_evt_o
);
  logic free;
  logic sw_go;
  logic edge_go;
  logic lvl_go;

  always_comb begin
    edge_hit_o = edge_seen(ctrl_i.pol, sync_i, sync_prev_i);
    lvl_act_o  = lvl_active(ctrl_i.pol, sync_i);
    // A decision point: idle, or the running sequence finishes this cycle.
    free       = ~busy_i | seq_done_i;

    sw_go   = ~ctrl_i.ext_en &
              ((sw_start_i & ~busy_i) | (busy_i & seq_done_i & ctrl_i.scan));
    edge_go = ctrl_i.ext_en & ~ctrl_i.lvl_mode & edge_hit_o & free;
    lvl_go  = ctrl_i.ext_en &  ctrl_i.lvl_mode & lvl_act_o  & free;

    launch_o  = sw_go | edge_go | lvl_go;
    ovr_evt_o = ctrl_i.ext_en & ~ctrl_i.lvl_mode & edge_hit_o & busy_i & ~seq_done_i;
  end

endmodule

// File: rtl/adc_trig_state.sv
module adc_trig_state (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic seq_done_i,
  input  logic ovr_evt_i,
  input  logic ovr_clr_i,
  output logic start_o,
  output logic busy_o,
  output logic ovr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      busy_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      start_o <= launch_i;
      if (launch_i)        busy_o <= 1'b1;
      else if (seq_done_i) busy_o <= 1'b0;
      if (ovr_evt_i)       ovr_o  <= 1'b1;
      else if (ovr_clr_i)  ovr_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_seq_trigger.sv
module adc_seq_trigger
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_en,
  input  logic lvl_mode,
  input  logic pol,
  input  logic scan,
  input  logic trig_pin,
  input  logic sw_start,
  input  logic seq_done,
  input  logic ovr_clr,
  output logic seq_start,
  output logic busy,
  output logic ovr_flag
);
  trig_ctrl_t ctrl;
  logic       sync_now;
  logic       sync_prev;
  logic       edge_hit;
  logic       lvl_act;
  logic       launch;
  logic       ovr_evt;

  assign ctrl = '{ext_en: ext_en, lvl_mode: lvl_mode, pol: pol, scan: scan};

  adc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (trig_pin),
    .sync_o     (sync_now),
    .sync_prev_o(sync_prev)
  );

  adc_trig_decide u_decide (
    .ctrl_i     (ctrl),
    .sync_i     (sync_now),
    .sync_prev_i(sync_prev),
    .sw_start_i (sw_start),
    .seq_done_i (seq_done),
    .busy_i     (busy),
    .edge_hit_o (edge_hit),
    .lvl_act_o  (lvl_act),
    .launch_o   (launch),
    .ovr_evt_o  (ovr_evt)
  );

  adc_trig_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (launch),
    .seq_done_i(seq_done),
    .ovr_evt_i (ovr_evt),
    .ovr_clr_i (ovr_clr),
    .start_o   (seq_start),
    .busy_o    (busy),
    .ovr_o     (ovr_flag)
  );

endmodule

// File: rtl/adc_seq_trigger_chk.sv
module adc_seq_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_en,
  input logic lvl_mode,
  input logic sw_start,
  input logic seq_done,
  input logic ovr_clr,
  input logic seq_start,
  input logic busy,
  input logic ovr_flag,
  input logic edge_hit,
  input logic lvl_act
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> busy);

  p_sw_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && !busy && !sw_start) |=> !seq_start);

  p_ext_blocks_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && !lvl_mode && !edge_hit) |=> !seq_start);

  p_edge_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && !lvl_mode && edge_hit && busy && !seq_done) |=> (ovr_flag && !seq_start));

  p_level_no_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && lvl_mode && !ovr_flag) |=> !ovr_flag);

  p_level_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && lvl_mode && lvl_act && busy && seq_done) |=> seq_start);

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy);

endmodule

bind adc_seq_trigger adc_seq_trigger_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ext_en   (ext_en),
  .lvl_mode (lvl_mode),
  .sw_start (sw_start),
  .seq_done (seq_done),
  .ovr_clr  (ovr_clr),
  .seq_start(seq_start),
  .busy     (busy),
  .ovr_flag (ovr_flag),
  .edge_hit (edge_hit),
  .lvl_act  (lvl_act)
);

// File: tb/tb_adc_seq_trigger.sv
module tb_adc_seq_trigger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_en = 1'b0, lvl_mode = 1'b0, pol = 1'b0, scan = 1'b0;
  logic trig_pin = 1'b0, sw_start = 1'b0, seq_done = 1'b0, ovr_clr = 1'b0;
  logic seq_start, busy, ovr_flag;

  int checks = 0;
  int errors = 0;
  int start_cnt = 0;
  int seq_len = 5;
  int dcnt = 0;
  string cur_req = "R12";

  // reference model state
  bit m_start = 0, m_busy = 0, m_ovr = 0;
  bit hist[3] = '{0, 0, 0};

  always #2 clk = ~clk;

  adc_seq_trigger dut (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .lvl_mode(lvl_mode), .pol(pol),
    .scan(scan), .trig_pin(trig_pin), .sw_start(sw_start), .seq_done(seq_done),
    .ovr_clr(ovr_clr), .seq_start(seq_start), .busy(busy), .ovr_flag(ovr_flag)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_min(string req, string what, int act, int lo);
    checks++;
    if (act < lo) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected>=%0d", req, what, act, lo);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Behavioural reference: pin samples kept as a history, one decision per edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_busy = 0; m_ovr = 0;
      hist = '{0, 0, 0};
    end else begin
      bit now_s, old_s, act, hit, idle_pt, go, ov;
      now_s = hist[1];
      old_s = hist[2];
      act = pol ? now_s : !now_s;
      hit = pol ? (now_s && !old_s) : (!now_s && old_s);
      idle_pt = !m_busy || seq_done;
      if (!ext_en)
        go = (sw_start && !m_busy) || (m_busy && seq_done && scan);
      else if (lvl_mode)
        go = act && idle_pt;
      else
        go = hit && idle_pt;
      ov = ext_en && !lvl_mode && hit && m_busy && !seq_done;
      m_start = go;
      if (go) m_busy = 1;
      else if (seq_done) m_busy = 0;
      if (ov) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = trig_pin;
    end
  end

  // Per-cycle comparison and conversion-engine responder.
  initial begin
    forever begin
      @(negedge clk);
      chk(cur_req, "seq_start vs model", seq_start, m_start);
      chk(cur_req, "busy vs model", busy, m_busy);
      chk(cur_req, "ovr_flag vs model", ovr_flag, m_ovr);
      if (seq_start) start_cnt++;
      if (busy) begin
        dcnt++;
        if (dcnt >= seq_len) begin
          seq_done = 1'b1;
          dcnt = 0;
        end else seq_done = 1'b0;
      end else begin
        seq_done = 1'b0;
        dcnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0;
    cyc(3);
    chk("R12", "seq_start in reset", seq_start, 1'b0);
    chk("R12", "busy in reset", busy, 1'b0);
    chk("R12", "ovr_flag in reset", ovr_flag, 1'b0);
    rst_n = 1'b1;
    cyc(2);

    // R1 software one-shot
    cur_req = "R1";
    s0 = start_cnt;
    sw_start = 1'b1; cyc(1); sw_start = 1'b0;
    cyc(40);
    chk_int("R1", "starts after one sw strobe", start_cnt - s0, 1);
    chk("R1", "busy after sequence", busy, 1'b0);

    // R2 software scan
    cur_req = "R2";
    scan = 1'b1; s0 = start_cnt;
    sw_start = 1'b1; cyc(1); sw_start = 1'b0;
    cyc(40);
    chk_min("R2", "starts in scan", start_cnt - s0, 4);
    scan = 1'b0; cyc(15);
    s0 = start_cnt; cyc(20);
    chk_int("R2", "starts after scan cleared", start_cnt - s0, 0);
    chk("R2", "busy after scan cleared", busy, 1'b0);

    // R5 external mode blocks software start and scan
    cur_req = "R5";
    ext_en = 1'b1; lvl_mode = 1'b0; pol = 1'b1; scan = 1'b1; trig_pin = 1'b0;
    cyc(5);
    s0 = start_cnt;
    sw_start = 1'b1; cyc(1); sw_start = 1'b0;
    cyc(20);
    chk_int("R5", "starts from sw strobe in ext mode", start_cnt - s0, 0);
    scan = 1'b0;

    // R10 latency and R3 rising edge
    cur_req = "R10";
    s0 = start_cnt;
    trig_pin = 1'b1;
    cyc(1); chk("R10", "seq_start after edge one", seq_start, 1'b0);
    cyc(1); chk("R10", "seq_start after edge two", seq_start, 1'b0);
    cyc(1); chk("R10", "seq_start after edge three", seq_start, 1'b1);
    cur_req = "R3";
    cyc(20);
    chk_int("R3", "starts per rising edge", start_cnt - s0, 1);
    s0 = start_cnt;
    trig_pin = 1'b0; cyc(20);
    chk_int("R3", "falling edge with pol=1", start_cnt - s0, 0);
    pol = 1'b0; cyc(3);
    s0 = start_cnt;
    trig_pin = 1'b1; cyc(20);
    chk_int("R3", "rising edge with pol=0", start_cnt - s0, 0);
    trig_pin = 1'b0; cyc(20);
    chk_int("R3", "falling edge with pol=0", start_cnt - s0, 1);

    // R6 edge overrun
    cur_req = "R6";
    pol = 1'b1; seq_len = 25; cyc(3);
    s0 = start_cnt;
    trig_pin = 1'b1; cyc(6);
    trig_pin = 1'b0; cyc(4);
    trig_pin = 1'b1; cyc(40);
    chk("R6", "ovr_flag after busy edge", ovr_flag, 1'b1);
    chk_int("R6", "no queued sequence", start_cnt - s0, 1);
    chk("R6", "busy after overrun", busy, 1'b0);

    // R9 sticky flag, clear, set wins
    cur_req = "R9";
    cyc(5);
    chk("R9", "flag still set", ovr_flag, 1'b1);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0;
    chk("R9", "flag after clear", ovr_flag, 1'b0);
    trig_pin = 1'b0; cyc(4);
    trig_pin = 1'b1; cyc(8);
    trig_pin = 1'b0; cyc(4);
    trig_pin = 1'b1; cyc(2);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0;
    chk("R9", "set beats clear", ovr_flag, 1'b1);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0;
    cyc(40);

    // R4 level active high, R8 restart
    cur_req = "R4";
    trig_pin = 1'b0; cyc(5);
    lvl_mode = 1'b1; seq_len = 5; cyc(3);
    s0 = start_cnt;
    trig_pin = 1'b1; cyc(40);
    chk_min("R4", "starts while high", start_cnt - s0, 4);
    cur_req = "R8";
    while (seq_done !== 1'b1) cyc(1);
    cyc(1);
    chk("R8", "start right after done", seq_start, 1'b1);
    cur_req = "R4";
    trig_pin = 1'b0; cyc(20);
    chk("R4", "busy after level dropped", busy, 1'b0);

    // R7 level toggle during sequence
    cur_req = "R7";
    seq_len = 25;
    trig_pin = 1'b1; cyc(6);
    trig_pin = 1'b0; cyc(3);
    trig_pin = 1'b1; cyc(40);
    chk("R7", "no overrun in level mode", ovr_flag, 1'b0);
    trig_pin = 1'b0; cyc(35);

    // R4 level active low
    cur_req = "R4";
    seq_len = 5;
    trig_pin = 1'b1; cyc(5);
    s0 = start_cnt;
    pol = 1'b0; trig_pin = 1'b0; cyc(30);
    chk_min("R4", "starts while low", start_cnt - s0, 3);
    trig_pin = 1'b1; cyc(20);
    chk("R4", "busy after low level left", busy, 1'b0);

    // R11 control change while busy
    cur_req = "R11";
    lvl_mode = 1'b0; pol = 1'b1; trig_pin = 1'b0; cyc(5);
    seq_len = 25;
    trig_pin = 1'b1; cyc(6);
    chk("R11", "busy after edge launch", busy, 1'b1);
    ext_en = 1'b0; lvl_mode = 1'b1; scan = 1'b0;
    cyc(5);
    chk("R11", "busy kept after control change", busy, 1'b1);
    cyc(30);
    chk("R11", "busy ends at done", busy, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule